// File: doc/BRIEF.md
# Serial Latch Programming and Fast-Lock Controller

This block is the digital programming front end of a frequency synthesizer. A host writes 24-bit words over a three-wire port made of a serial clock, a serial data line and a load strobe. A word is shifted in with its most significant bit first. On the rising edge of the load strobe, the two lowest bits of the word pick one of three holding latches: the reference divider value, the feedback divider values (swallow count, main count and charge-pump gain flag), or the function settings.

The block also runs the fast-lock controller. This controller chooses which of two 3-bit charge-pump current codes is active. In its timed mode, a write that sets the gain flag starts a timer. The timer counts phase-detector cycles, given as single-cycle strobes on `pfdTick`. When the programmed interval ends, the timer clears the gain flag and the primary current code returns. The power-down controls come from a chip-enable pin and a software bit. They force the charge pump into three-state, hold the counters in reset and reset the lock detector.

All serial inputs are sampled in the `clk` domain through a synchronizer, and the host must keep each serial level stable for several `clk` cycles.

Top module: `synth_prog_top`

## Requirements
- R1: Each rising edge of `serClk` shifts `serData` into bit 0 of a 24-bit register, so the first bit sent ends in bit 23.
- R2: A rising edge of `serLoad` copies the register to a latch chosen by bits 1:0: code 00 selects the reference latch, 01 the divider latch and 10 the function latch.
- R3: A load with code 11 changes no output.
- R4: The reference latch drives `refDiv` from bits 15:2.
- R5: The divider latch drives `aCnt` from bits 7:2, `bCnt` from bits 20:8 and `cpGain` from bit 21.
- R6: The function latch decodes these fields: bit 2 counter reset, bit 3 software power-down, bits 6:4 `muxSel`, bit 7 `pdPolarity`, bit 8 three-state request, bit 9 fast-lock enable, bit 10 fast-lock mode, bits 14:11 timer code TC, bits 17:15 primary current, bits 20:18 boost current, and bits 23:22 `prescSel`.
- R7: `activeCurrent` equals the boost current when fast-lock is enabled and `cpGain` is 1. Otherwise it equals the primary current.
- R8: In mode 0 (bit 10 = 0), `cpGain` stays set regardless of how many phase-detector cycles pass, until a divider write clears it.
- R9: In mode 1 with fast-lock enabled, a divider write with gain 1 starts a timer. After 3 + 4·TC phase-detector ticks (3 for TC = 0, 63 for TC = 15), `cpGain` clears and the primary current returns.
- R10: A new divider write with gain 1 restarts a running timer from its full length. A divider write with gain 0 cancels the timer.
- R11: `powerDown` is high whenever `chipEn` is low or the software power-down bit is set. While it is high, `cpTriState`, `counterReset` and `lockDetRst` are high, and phase-detector ticks do not advance the timer.
- R12: Writes to all latches still take effect while the block is powered down.
- R13: After reset, every latched field and `activeCurrent` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| serClk | input | 1 | Serial shift clock, sampled |
| serData | input | 1 | Serial data, MSB first |
| serLoad | input | 1 | Load strobe, rising edge commits the word |
| chipEn | input | 1 | Chip enable, low forces power-down |
| pfdTick | input | 1 | One-cycle strobe per phase-detector cycle |
| refDiv | output | 14 | Reference divide value |
| aCnt | output | 6 | Swallow counter value |
| bCnt | output | 13 | Main counter value |
| cpGain | output | 1 | Stored charge-pump gain flag |
| prescSel | output | 2 | Prescaler modulus select |
| muxSel | output | 3 | Output multiplexer select |
| pdPolarity | output | 1 | Phase detector polarity |
| cpTriState | output | 1 | Charge pump three-state control |
| powerDown | output | 1 | Combined power-down |
| counterReset | output | 1 | Divider counters held in reset |
| lockDetRst | output | 1 | Lock detector reset |
| activeCurrent | output | 3 | Selected charge-pump current code |

## Verification
A table of words is shifted through the port. The table covers all-ones and minimum divider fields, several function settings with mixed bits, and a code-11 word full of ones. Comparing every output after each word against a field model catches swapped latch routing, misplaced or reversed fields, and a write that leaks from the reserved code. Timed fast-lock runs use TC values 0, 1 and 15, with the output sampled one tick before expiry and exactly at expiry, which exposes off-by-one interval errors. Further runs separate restart from cancel, mode 0 from mode 1, a disabled fast-lock from an enabled one, and ticks during power-down from ticks while powered up.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;

  localparam int CTL_W = 2;

  // Field positions that the latch consumers decode
  localparam int REF_LSB   = 2;
  localparam int A_LSB     = 2;
  localparam int B_LSB     = 8;
  localparam int GAIN_BIT  = 21;
  localparam int F_CRST    = 2;
  localparam int F_PD      = 3;
  localparam int F_MUX_LSB = 4;
  localparam int F_POL     = 7;
  localparam int F_TRI     = 8;
  localparam int F_FLEN    = 9;
  localparam int F_FLMODE  = 10;
  localparam int F_TC_LSB  = 11;
  localparam int F_CS1_LSB = 15;
  localparam int F_CS2_LSB = 18;
  localparam int F_PRE_LSB = 22;

  typedef enum logic [CTL_W-1:0] {
    SEL_REF  = 2'b00,
    SEL_DIV  = 2'b01,
    SEL_FUNC = 2'b10,
    SEL_NONE = 2'b11
  } latchSel_t;

  typedef struct packed {
    logic shift;
    logic bitIn;
    logic loadRef;
    logic loadDiv;
    logic loadFunc;
  } progStrobe_t;

endpackage

// File: rtl/synth_prog_seq.sv
module synth_prog_seq
  import synth_prog_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int NUM_LATCH   = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             serClk,
  input  logic             serData,
  input  logic             serLoad,
  input  logic [CTL_W-1:0] ctlBits,
  output progStrobe_t      strobe
);

  logic [SYNC_STAGES:0]   clkPipe;
  logic [SYNC_STAGES:0]   ldPipe;
  logic [SYNC_STAGES-1:0] datPipe;
  logic                   clkRise;
  logic                   ldRise;
  logic [NUM_LATCH-1:0]   loadVec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkPipe <= '0;
      ldPipe  <= '0;
      datPipe <= '0;
    end else begin
      clkPipe <= {clkPipe[SYNC_STAGES-1:0], serClk};
      ldPipe  <= {ldPipe[SYNC_STAGES-1:0], serLoad};
      datPipe <= {datPipe[SYNC_STAGES-2:0], serData};
    end
  end

  assign clkRise = clkPipe[SYNC_STAGES-1] & ~clkPipe[SYNC_STAGES];
  assign ldRise  = ldPipe[SYNC_STAGES-1] & ~ldPipe[SYNC_STAGES];

  // One load strobe per decodable latch code; code 11 has no strobe
  for (genvar g = 0; g < NUM_LATCH; g++) begin : gLoadDec
    assign loadVec[g] = ldRise && (ctlBits == CTL_W'(g));
  end

  assign strobe.shift    = clkRise;
  assign strobe.bitIn    = datPipe[SYNC_STAGES-1];
  assign strobe.loadRef  = loadVec[SEL_REF];
  assign strobe.loadDiv  = loadVec[SEL_DIV];
  assign strobe.loadFunc = loadVec[SEL_FUNC];

  // R1: a serial clock edge yields exactly one shift
  assert_single_shift_R1: assert property (@(posedge clk) disable iff (!rstN)
    clkRise |=> !clkRise);

endmodule

// File: rtl/synth_prog_dp.sv
module synth_prog_dp
  import synth_prog_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int REF_W  = 14,
  parameter int A_W    = 6,
  parameter int B_W    = 13,
  parameter int CUR_W  = 3,
  parameter int TC_W   = 4,
  parameter int MUX_W  = 3,
  parameter int PRE_W  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  progStrobe_t      strobe,
  input  logic             pfdTick,
  input  logic             chipEn,
  output logic [CTL_W-1:0] ctlBits,
  output logic [REF_W-1:0] refDiv,
  output logic [A_W-1:0]   aCnt,
  output logic [B_W-1:0]   bCnt,
  output logic             cpGain,
  output logic [PRE_W-1:0] prescSel,
  output logic [MUX_W-1:0] muxSel,
  output logic             pdPolarity,
  output logic             cpTriState,
  output logic             powerDown,
  output logic             counterReset,
  output logic             lockDetRst,
  output logic [CUR_W-1:0] activeCurrent
);

  localparam int TMR_W = TC_W + 2;

  logic [WORD_W-1:0] shiftReg;
  logic              crstQ, pdQ, polQ, triQ, flEnQ, flModeQ;
  logic [MUX_W-1:0]  muxQ;
  logic [TC_W-1:0]   tcQ;
  logic [CUR_W-1:0]  cs1Q, cs2Q;
  logic [PRE_W-1:0]  preQ;
  logic [TMR_W-1:0]  tmrCnt;
  logic              tickEff;
  logic              newGain;

  always_ff @(posedge clk) begin
    if (!rstN) shiftReg <= '0;
    else if (strobe.shift) shiftReg <= {shiftReg[WORD_W-2:0], strobe.bitIn};
  end

  assign ctlBits = shiftReg[CTL_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) refDiv <= '0;
    else if (strobe.loadRef) refDiv <= shiftReg[REF_LSB +: REF_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aCnt <= '0;
      bCnt <= '0;
    end else if (strobe.loadDiv) begin
      aCnt <= shiftReg[A_LSB +: A_W];
      bCnt <= shiftReg[B_LSB +: B_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crstQ <= 1'b0; pdQ <= 1'b0; polQ <= 1'b0; triQ <= 1'b0;
      flEnQ <= 1'b0; flModeQ <= 1'b0;
      muxQ <= '0; tcQ <= '0; cs1Q <= '0; cs2Q <= '0; preQ <= '0;
    end else if (strobe.loadFunc) begin
      crstQ   <= shiftReg[F_CRST];
      pdQ     <= shiftReg[F_PD];
      muxQ    <= shiftReg[F_MUX_LSB +: MUX_W];
      polQ    <= shiftReg[F_POL];
      triQ    <= shiftReg[F_TRI];
      flEnQ   <= shiftReg[F_FLEN];
      flModeQ <= shiftReg[F_FLMODE];
      tcQ     <= shiftReg[F_TC_LSB +: TC_W];
      cs1Q    <= shiftReg[F_CS1_LSB +: CUR_W];
      cs2Q    <= shiftReg[F_CS2_LSB +: CUR_W];
      preQ    <= shiftReg[F_PRE_LSB +: PRE_W];
    end
  end

  // Power-down: pin has priority, acts without waiting for a clock edge
  assign powerDown    = ~chipEn | pdQ;
  assign cpTriState   = triQ | powerDown;
  assign counterReset = crstQ | powerDown;
  assign lockDetRst   = powerDown;
  assign muxSel       = muxQ;
  assign pdPolarity   = polQ;
  assign prescSel     = preQ;

  // Fast-lock gain flag and timeout timer (interval = 4*TC + 3)
  assign tickEff = pfdTick & ~powerDown;
  assign newGain = shiftReg[GAIN_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cpGain <= 1'b0;
      tmrCnt <= '0;
    end else if (strobe.loadDiv) begin
      cpGain <= newGain;
      tmrCnt <= (newGain && flEnQ && flModeQ) ? {tcQ, 2'b11} : '0;
    end else if (tickEff && (tmrCnt != '0)) begin
      tmrCnt <= tmrCnt - 1'b1;
      if (tmrCnt == TMR_W'(1)) cpGain <= 1'b0;
    end
  end

  assign activeCurrent = (flEnQ && cpGain) ? cs2Q : cs1Q;

  // R1: shift moves the word up one place and inserts the sampled bit
  assert_shift_order_R1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shift |=> (shiftReg[0] == $past(strobe.bitIn)) &&
                     (shiftReg[WORD_W-1:1] == $past(shiftReg[WORD_W-2:0])));

  // R3: at most one latch is written per load
  assert_one_latch_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.loadRef, strobe.loadDiv, strobe.loadFunc}));

  // R9: a running timer implies the gain flag is still set
  assert_timer_gain_R9: assert property (@(posedge clk) disable iff (!rstN)
    (tmrCnt != '0) |-> cpGain);

  // R9: the last counted tick clears the gain flag
  assert_auto_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    (tickEff && (tmrCnt == TMR_W'(1)) && !strobe.loadDiv) |=> !cpGain);

  // R11: no timer progress while powered down
  assert_timer_frozen_R11: assert property (@(posedge clk) disable iff (!rstN)
    (powerDown && !strobe.loadDiv) |=> $stable(tmrCnt));

endmodule

// File: rtl/synth_prog_top.sv
module synth_prog_top
  import synth_prog_pkg::*;
#(
  parameter int WORD_W      = 24,
  parameter int SYNC_STAGES = 2,
  parameter int REF_W       = 14,
  parameter int A_W         = 6,
  parameter int B_W         = 13,
  parameter int CUR_W       = 3,
  parameter int TC_W        = 4,
  parameter int MUX_W       = 3,
  parameter int PRE_W       = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             serClk,
  input  logic             serData,
  input  logic             serLoad,
  input  logic             chipEn,
  input  logic             pfdTick,
  output logic [REF_W-1:0] refDiv,
  output logic [A_W-1:0]   aCnt,
  output logic [B_W-1:0]   bCnt,
  output logic             cpGain,
  output logic [PRE_W-1:0] prescSel,
  output logic [MUX_W-1:0] muxSel,
  output logic             pdPolarity,
  output logic             cpTriState,
  output logic             powerDown,
  output logic             counterReset,
  output logic             lockDetRst,
  output logic [CUR_W-1:0] activeCurrent
);

  progStrobe_t      strobe;
  logic [CTL_W-1:0] ctlBits;

  synth_prog_seq #(
    .SYNC_STAGES(SYNC_STAGES),
    .NUM_LATCH  (3)
  ) seq_i (
    .clk    (clk),
    .rstN   (rstN),
    .serClk (serClk),
    .serData(serData),
    .serLoad(serLoad),
    .ctlBits(ctlBits),
    .strobe (strobe)
  );

  synth_prog_dp #(
    .WORD_W(WORD_W), .REF_W(REF_W), .A_W(A_W), .B_W(B_W),
    .CUR_W(CUR_W), .TC_W(TC_W), .MUX_W(MUX_W), .PRE_W(PRE_W)
  ) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .pfdTick      (pfdTick),
    .chipEn       (chipEn),
    .ctlBits      (ctlBits),
    .refDiv       (refDiv),
    .aCnt         (aCnt),
    .bCnt         (bCnt),
    .cpGain       (cpGain),
    .prescSel     (prescSel),
    .muxSel       (muxSel),
    .pdPolarity   (pdPolarity),
    .cpTriState   (cpTriState),
    .powerDown    (powerDown),
    .counterReset (counterReset),
    .lockDetRst   (lockDetRst),
    .activeCurrent(activeCurrent)
  );

  // R11: a low enable pin takes effect on all power-down outputs
  assert_pin_powerdown_R11: assert property (@(posedge clk) disable iff (!rstN)
    !chipEn |-> (powerDown && cpTriState && counterReset && lockDetRst));

endmodule

// File: tb/synth_prog_top_tb_top.sv
module synth_prog_top_tb_top;

  logic clk = 1'b0;
  logic rstN, serClk, serData, serLoad, chipEn, pfdTick;
  logic [13:0] refDiv;
  logic [5:0]  aCnt;
  logic [12:0] bCnt;
  logic        cpGain, pdPolarity, cpTriState, powerDown, counterReset, lockDetRst;
  logic [1:0]  prescSel;
  logic [2:0]  muxSel, activeCurrent;

  int chkCnt = 0;
  int failCnt = 0;

  // bench field model
  logic [13:0] mRef = '0;
  logic [5:0]  mA = '0;
  logic [12:0] mB = '0;
  logic        mGain = 1'b0;
  logic [23:0] mFunc = '0;

  always #2 clk = ~clk;

  synth_prog_top dut_i (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData), .serLoad(serLoad),
    .chipEn(chipEn), .pfdTick(pfdTick), .refDiv(refDiv), .aCnt(aCnt), .bCnt(bCnt),
    .cpGain(cpGain), .prescSel(prescSel), .muxSel(muxSel), .pdPolarity(pdPolarity),
    .cpTriState(cpTriState), .powerDown(powerDown), .counterReset(counterReset),
    .lockDetRst(lockDetRst), .activeCurrent(activeCurrent)
  );

  localparam int NVEC = 9;
  localparam logic [23:0] VEC [NVEC] = '{
    24'h00FFFC, 24'h000004, 24'h1FFFFD, 24'h2ABCDE, 24'h200105,
    24'hC5A4F2, 24'hFFFFFF, 24'h012346, 24'h000001
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    chkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic modelWrite(input logic [23:0] w);
    case (w[1:0])
      2'b00: mRef = w[15:2];
      2'b01: begin mA = w[7:2]; mB = w[20:8]; mGain = w[21]; end
      2'b10: mFunc = w;
      default: ;
    endcase
  endtask

  task automatic checkAll(input string tag);
    logic expPd;
    expPd = !chipEn | mFunc[3];
    chk({tag, " R4"},  "refDiv", 32'(refDiv), 32'(mRef));
    chk({tag, " R5"},  "aCnt", 32'(aCnt), 32'(mA));
    chk({tag, " R5"},  "bCnt", 32'(bCnt), 32'(mB));
    chk({tag, " R5"},  "cpGain", 32'(cpGain), 32'(mGain));
    chk({tag, " R6"},  "prescSel", 32'(prescSel), 32'(mFunc[23:22]));
    chk({tag, " R6"},  "muxSel", 32'(muxSel), 32'(mFunc[6:4]));
    chk({tag, " R6"},  "pdPolarity", 32'(pdPolarity), 32'(mFunc[7]));
    chk({tag, " R6"},  "cpTriState", 32'(cpTriState), 32'(mFunc[8] | expPd));
    chk({tag, " R6"},  "counterReset", 32'(counterReset), 32'(mFunc[2] | expPd));
    chk({tag, " R11"}, "powerDown", 32'(powerDown), 32'(expPd));
    chk({tag, " R11"}, "lockDetRst", 32'(lockDetRst), 32'(expPd));
    chk({tag, " R7"},  "activeCurrent", 32'(activeCurrent),
        32'((mFunc[9] && mGain) ? mFunc[20:18] : mFunc[17:15]));
  endtask

  task automatic sendWord(input logic [23:0] w);
    for (int i = 23; i >= 0; i--) begin
      @(negedge clk) serData = w[i];
      repeat (3) @(negedge clk);
      serClk = 1'b1;
      repeat (4) @(negedge clk);
      serClk = 1'b0;
      repeat (2) @(negedge clk);
    end
    serLoad = 1'b1;
    repeat (4) @(negedge clk);
    serLoad = 1'b0;
    repeat (4) @(negedge clk);
    modelWrite(w);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) pfdTick = 1'b1;
      @(negedge clk) pfdTick = 1'b0;
    end
  endtask

  function automatic logic [23:0] mkFunc(input logic en, input logic mode, input logic [3:0] tc,
                                         input logic [2:0] cs1, input logic [2:0] cs2);
    return (24'(cs2) << 18) | (24'(cs1) << 15) | (24'(tc) << 11) |
           (24'(mode) << 10) | (24'(en) << 9) | 24'h2;
  endfunction

  function automatic logic [23:0] mkDiv(input logic [5:0] a, input logic [12:0] b, input logic g);
    return (24'(g) << 21) | (24'(b) << 8) | (24'(a) << 2) | 24'h1;
  endfunction

  task automatic timedRun(input logic [3:0] tc);
    int len;
    len = 4 * int'(tc) + 3;
    sendWord(mkFunc(1'b1, 1'b1, tc, 3'd2, 3'd5));
    sendWord(mkDiv(6'd3, 13'd40, 1'b1));
    chk("R9", "boost active", 32'(activeCurrent), 32'd5);
    ticks(len - 1);
    chk("R9", "gain before expiry", 32'(cpGain), 32'd1);
    chk("R9", "boost before expiry", 32'(activeCurrent), 32'd5);
    ticks(1);
    chk("R9", "gain cleared at expiry", 32'(cpGain), 32'd0);
    chk("R9", "primary restored", 32'(activeCurrent), 32'd2);
    mGain = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", chkCnt, failCnt);
    $finish;
  end

  initial begin
    rstN = 1'b0; serClk = 1'b0; serData = 1'b0; serLoad = 1'b0;
    chipEn = 1'b1; pfdTick = 1'b0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R13 reset");

    // table walk: R1 R2 R3 field placement, routing, code 11 ignored
    for (int v = 0; v < NVEC; v++) begin
      sendWord(VEC[v]);
      checkAll((VEC[v][1:0] == 2'b11) ? "R3 R2 R1 vec" : "R2 R1 vec");
    end

    // R9 interval lengths at both ends and in between
    timedRun(4'd0);
    timedRun(4'd1);
    timedRun(4'd15);
    checkAll("R9 after timer");

    // R10 restart and cancel
    sendWord(mkFunc(1'b1, 1'b1, 4'd1, 3'd2, 3'd5));
    sendWord(mkDiv(6'd1, 13'd9, 1'b1));
    ticks(4);
    sendWord(mkDiv(6'd1, 13'd9, 1'b1));
    ticks(6);
    chk("R10", "restart keeps boost", 32'(activeCurrent), 32'd5);
    ticks(1);
    chk("R10", "restart full length", 32'(activeCurrent), 32'd2);
    mGain = 1'b0;
    sendWord(mkDiv(6'd1, 13'd9, 1'b1));
    ticks(2);
    sendWord(mkDiv(6'd1, 13'd9, 1'b0));
    chk("R10", "cancel clears gain", 32'(cpGain), 32'd0);
    sendWord(mkDiv(6'd1, 13'd9, 1'b1));
    ticks(6);
    chk("R10", "fresh run after cancel", 32'(cpGain), 32'd1);
    ticks(1);
    chk("R10", "fresh run expires", 32'(cpGain), 32'd0);
    mGain = 1'b0;

    // R8 mode 0 holds until rewritten
    sendWord(mkFunc(1'b1, 1'b0, 4'd0, 3'd2, 3'd5));
    sendWord(mkDiv(6'd2, 13'd7, 1'b1));
    ticks(70);
    chk("R8", "gain held", 32'(cpGain), 32'd1);
    chk("R8", "boost held", 32'(activeCurrent), 32'd5);
    sendWord(mkDiv(6'd2, 13'd7, 1'b0));
    chk("R8", "write clears", 32'(activeCurrent), 32'd2);

    // R7 fast-lock disabled: primary current regardless of gain
    sendWord(mkFunc(1'b0, 1'b1, 4'd0, 3'd6, 3'd1));
    sendWord(mkDiv(6'd2, 13'd7, 1'b1));
    ticks(5);
    chk("R7", "disabled uses primary", 32'(activeCurrent), 32'd6);
    chk("R7", "disabled gain kept", 32'(cpGain), 32'd1);
    checkAll("R7 disabled");

    // R11 R12 power-down via pin
    sendWord(mkFunc(1'b1, 1'b1, 4'd0, 3'd2, 3'd5));
    sendWord(mkDiv(6'd4, 13'd11, 1'b1));
    @(negedge clk) chipEn = 1'b0;
    @(negedge clk);
    checkAll("R11 pin low");
    ticks(5);
    chk("R11", "ticks ignored in power-down", 32'(cpGain), 32'd1);
    sendWord(24'h00A5A8);
    chk("R12", "write during power-down", 32'(refDiv), 32'(24'h00A5A8 >> 2) & 32'h3FFF);
    @(negedge clk) chipEn = 1'b1;
    @(negedge clk);
    checkAll("R11 pin high");
    ticks(2);
    chk("R11", "timer resumes", 32'(cpGain), 32'd1);
    ticks(1);
    chk("R11", "timer expires after resume", 32'(cpGain), 32'd0);
    mGain = 1'b0;

    // R11 software power-down bit
    sendWord(mkFunc(1'b0, 1'b0, 4'd0, 3'd3, 3'd4) | 24'h8);
    checkAll("R11 soft bit");

    $display("End of test - %0d assertions evaluated, %0d failures", chkCnt, failCnt);
    $finish;
  end

endmodule